// File: doc/BRIEF.md
# Bucket Conflict Delayed Scheduler

This block sits in front of a pipelined point accumulator whose operations take a fixed LAT cycles to finish. Each incoming item carries a bucket index (a reduced scalar of IDX_W bits) and a point tag. The block places at most one item per cycle into the accumulator issue slot. It also makes sure that no bucket index is issued again while an earlier operation on that bucket is still in flight.

When an item's bucket is busy, the block does not stall. It moves the item into a retry queue, and the item is offered again on later cycles. The accumulator is modelled here as a LAT-deep delay line of bucket indices. Its output marks the cycle in which each bucket is freed.

A retry item is issued as soon as its bucket is free, and it takes the issue slot ahead of new input. Once the input stream has been marked as ended, the queue is empty and the delay line has drained, the block raises a completion flag.

Top module: `bucket_sched`

## Requirements
- R1: While reset is held and no input is valid, `iss_valid`, `ret_valid` and `done` are 0 and `in_ready` is 1.
- R2: Two issues of the same bucket index are always at least LAT cycles apart. A gap of exactly LAT cycles is legal.
- R3: Every issue made in cycle t produces `ret_valid`=1 in cycle t+LAT, with `ret_idx` equal to the issued index. No other cycle shows a retire.
- R4: When the retry queue is not empty and the bucket of its oldest entry is free, that entry is issued in this cycle, ahead of any new input. Queue entries leave strictly in the order they entered.
- R5: When no retry entry is issued and a valid input's bucket is free, the input is issued in the same cycle with its index and tag unchanged.
- R6: An accepted input is pushed into the retry queue in two cases: its bucket is busy, or a retry entry takes the slot in that cycle.
- R7: `in_ready` is 0 only when all three hold: the retry queue is full, no retry entry is issued this cycle, and the input's bucket is busy.
- R8: A bucket that retires in a cycle counts as free in that same cycle, so it can be issued again in the cycle of its retire.
- R9: `done` is 1 exactly when all three hold: an input with `in_last`=1 has been accepted, the retry queue is empty, and no operation remains in the delay line. While `done` is 1 there is no issue and no retire.
- R10: Every accepted item is issued exactly once, carrying its own tag.
- R11: When 2**IDX_W exceeds MAP_MAX, busy buckets are found by searching the delay line instead of a bitmap. The port behaviour is identical to the bitmap variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Input item accepted this cycle when high |
| in_idx | input | IDX_W | Bucket index of the input item |
| in_tag | input | TAG_W | Point tag of the input item |
| in_last | input | 1 | Marks the final item of the stream |
| iss_valid | output | 1 | An operation is issued to the accumulator this cycle |
| iss_idx | output | IDX_W | Bucket index of the issued operation |
| iss_tag | output | TAG_W | Point tag of the issued operation |
| ret_valid | output | 1 | An operation leaves the delay line this cycle |
| ret_idx | output | IDX_W | Bucket freed by the retiring operation |
| done | output | 1 | Stream ended and all work drained |

## Verification
Retire and issue of the same bucket can fall in one cycle, and this is the corner that matters most. The retire must clear the busy mark before the new issue sets it. Otherwise the item is deferred by one full pass, or the mark is lost.

The bench provokes this corner in two ways. First, it sends an item on a bucket exactly LAT cycles after that bucket's previous issue. Second, it keeps a full retry queue of one repeated bucket, so that each queued entry waits for the retire of the entry before it. A behavioural model tracks the last issue cycle of every bucket. It expects the reissue in the retire cycle, and it compares issue, retire, ready and completion against the design on every clock.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

    // Which source owns the issue slot in a cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_RETRY = 2'd1,
        SRC_INPUT = 2'd2
    } src_e;

endpackage

// File: rtl/bsched_fifo.sv
module bsched_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t s_d, s_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp          = bump(s_q.wp);
        end
        if (pop) begin
            s_d.rp = bump(s_q.rp);
        end
        if (push && !pop) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop && !push) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.mem[s_q.rp];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CNT_W'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/bsched_busy.sv
module bsched_busy #(
    parameter int IDX_W   = 16,
    parameter int LAT     = 96,
    parameter int MAP_MAX = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] qa_idx,
    input  logic [IDX_W-1:0] qb_idx,
    output logic             qa_hit,
    output logic             qb_hit,
    output logic             ret_vld,
    output logic [IDX_W-1:0] ret_idx,
    output logic             any_busy
);

    localparam int NBKT = 1 << IDX_W;

    typedef struct packed {
        logic [LAT-1:0]            vld;
        logic [LAT-1:0][IDX_W-1:0] idx;
    } line_t;

    line_t line_d, line_q;

    // Delay line: stage 0 takes the issue, stage LAT-1 retires
    always_comb begin
        line_d.vld = {line_q.vld[LAT-2:0], set_vld};
        line_d.idx = {line_q.idx[LAT-2:0], set_idx};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign ret_vld  = line_q.vld[LAT-1];
    assign ret_idx  = line_q.idx[LAT-1];
    assign any_busy = |line_q.vld;

    generate
        if (NBKT <= MAP_MAX) begin : gen_map
            logic [NBKT-1:0] map_d, map_q, map_eff;

            // Retire clears before the new issue sets
            always_comb begin
                map_eff = map_q;
                if (ret_vld) begin
                    map_eff[ret_idx] = 1'b0;
                end
                map_d = map_eff;
                if (set_vld) begin
                    map_d[set_idx] = 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    map_q <= '0;
                end else begin
                    map_q <= map_d;
                end
            end

            assign qa_hit = map_eff[qa_idx];
            assign qb_hit = map_eff[qb_idx];

            // R3
            retire_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ret_vld |-> map_q[ret_idx]);

            // R2
            issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_vld |-> !map_eff[set_idx]);
        end else begin : gen_cam
            logic set_clash;

            // The retiring stage is excluded: it frees its bucket this cycle
            always_comb begin
                qa_hit    = 1'b0;
                qb_hit    = 1'b0;
                set_clash = 1'b0;
                for (int k = 0; k < LAT - 1; k++) begin
                    if (line_q.vld[k] && line_q.idx[k] == qa_idx) qa_hit = 1'b1;
                    if (line_q.vld[k] && line_q.idx[k] == qb_idx) qb_hit = 1'b1;
                    if (line_q.vld[k] && line_q.idx[k] == set_idx) set_clash = 1'b1;
                end
            end

            // R2
            issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_vld |-> !set_clash);
        end
    endgenerate

endmodule

// File: rtl/bucket_sched.sv
module bucket_sched
    import bsched_pkg::*;
#(
    parameter int IDX_W       = 16,
    parameter int TAG_W       = 32,
    parameter int LAT         = 96,
    parameter int RETRY_DEPTH = 64,
    parameter int MAP_MAX     = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_last,
    output logic             iss_valid,
    output logic [IDX_W-1:0] iss_idx,
    output logic [TAG_W-1:0] iss_tag,
    output logic             ret_valid,
    output logic [IDX_W-1:0] ret_idx,
    output logic             done
);

    localparam int ENT_W = IDX_W + TAG_W;

    typedef struct packed {
        logic ended;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [ENT_W-1:0] fifo_rdata;
    logic [IDX_W-1:0] head_idx;
    logic [TAG_W-1:0] head_tag;
    logic             head_hit, in_hit, any_busy;
    logic             retry_go, in_take;
    src_e             src;

    assign head_idx = fifo_rdata[ENT_W-1:TAG_W];
    assign head_tag = fifo_rdata[TAG_W-1:0];

    always_comb begin
        ctl_d     = ctl_q;
        retry_go  = !fifo_empty && !head_hit;
        in_ready  = retry_go || !fifo_full || !in_hit;
        in_take   = in_valid && in_ready;
        src       = SRC_NONE;
        if (retry_go) begin
            src = SRC_RETRY;
        end else if (in_valid && !in_hit) begin
            src = SRC_INPUT;
        end
        fifo_pop  = retry_go;
        fifo_push = in_take && (retry_go || in_hit);
        iss_valid = (src != SRC_NONE);
        iss_idx   = (src == SRC_RETRY) ? head_idx : in_idx;
        iss_tag   = (src == SRC_RETRY) ? head_tag : in_tag;
        if (in_take && in_last) begin
            ctl_d.ended = 1'b1;
        end
        done = ctl_q.ended && fifo_empty && !any_busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bsched_fifo #(
        .W     (ENT_W),
        .DEPTH (RETRY_DEPTH)
    ) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .wdata ({in_idx, in_tag}),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    bsched_busy #(
        .IDX_W   (IDX_W),
        .LAT     (LAT),
        .MAP_MAX (MAP_MAX)
    ) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (iss_valid),
        .set_idx  (iss_idx),
        .qa_idx   (head_idx),
        .qb_idx   (in_idx),
        .qa_hit   (head_hit),
        .qb_hit   (in_hit),
        .ret_vld  (ret_valid),
        .ret_idx  (ret_idx),
        .any_busy (any_busy)
    );

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!iss_valid && !ret_valid));

    // R7
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (fifo_full && in_hit && head_hit));

    // R5
    direct_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fifo_empty && !in_hit) |-> (iss_valid && iss_tag == in_tag));

    // R4
    retry_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_empty && !head_hit) |-> (iss_valid && iss_tag == head_tag && in_ready));

endmodule

// File: tb/bucket_sched_bench.sv
`timescale 1ns/100ps
module bucket_sched_bench;

    localparam int IDX_W = 3;
    localparam int TAG_W = 12;
    localparam int LAT   = 6;
    localparam int DEPTH = 4;
    localparam int NB    = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IDX_W-1:0] in_idx = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic             in_last = 1'b0;
    logic             in_ready, iss_valid, ret_valid, done;
    logic [IDX_W-1:0] iss_idx, ret_idx;
    logic [TAG_W-1:0] iss_tag;
    logic             c_ready, c_iss_valid, c_ret_valid, c_done;
    logic [IDX_W-1:0] c_iss_idx, c_ret_idx;
    logic [TAG_W-1:0] c_iss_tag;

    int checks = 0;
    int fails  = 0;
    int accepted = 0;
    int issued   = 0;
    int next_tag = 1;
    int lcg      = 12345;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bucket_sched #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LAT(LAT), .RETRY_DEPTH(DEPTH))
    u_bucket_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_idx(in_idx), .in_tag(in_tag), .in_last(in_last),
        .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_tag(iss_tag),
        .ret_valid(ret_valid), .ret_idx(ret_idx), .done(done)
    );

    bucket_sched #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LAT(LAT), .RETRY_DEPTH(DEPTH),
                   .MAP_MAX(0))
    u_bucket_sched_cam (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_ready),
        .in_idx(in_idx), .in_tag(in_tag), .in_last(in_last),
        .iss_valid(c_iss_valid), .iss_idx(c_iss_idx), .iss_tag(c_iss_tag),
        .ret_valid(c_ret_valid), .ret_idx(c_ret_idx), .done(c_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    typedef struct { int idx; int tag; } ent_t;
    typedef struct { int t; int idx; } fl_t;
    ent_t fq[$];
    fl_t  infl[$];
    int   last_t[NB];
    int   obs_last[NB];
    bit   tag_seen[int];
    int   cyc = 0;
    bit   ended = 1'b0;

    initial begin
        for (int b = 0; b < NB; b++) begin
            last_t[b]   = -1000;
            obs_last[b] = -1000;
        end
    end

    function automatic bit busy(input int b);
        return (cyc - last_t[b]) < LAT;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit   rgo, ihit, ex_ready, ex_iss, ex_ret, ex_done, take;
            ent_t ex_e;
            int   ex_ret_idx;
            while (infl.size() > 0 && infl[0].t + LAT < cyc) void'(infl.pop_front());
            ex_ret     = (infl.size() > 0 && infl[0].t + LAT == cyc);
            ex_ret_idx = ex_ret ? infl[0].idx : 0;
            rgo        = (fq.size() > 0) && !busy(fq[0].idx);
            ihit       = busy(int'(in_idx));
            ex_ready   = rgo || (fq.size() < DEPTH) || !ihit;
            ex_iss     = 1'b0;
            ex_e.idx   = 0;
            ex_e.tag   = 0;
            if (rgo) begin
                ex_iss = 1'b1; ex_e = fq[0];
            end else if (in_valid && !ihit) begin
                ex_iss = 1'b1; ex_e.idx = int'(in_idx); ex_e.tag = int'(in_tag);
            end
            ex_done = ended && fq.size() == 0 && infl.size() == 0;

            // R4 R5: issue slot contents
            chk(iss_valid == ex_iss, "R4/R5", "iss_valid", int'(iss_valid), int'(ex_iss));
            if (ex_iss && iss_valid) begin
                chk(int'(iss_idx) == ex_e.idx, "R4/R5", "iss_idx", int'(iss_idx), ex_e.idx);
                chk(int'(iss_tag) == ex_e.tag, "R10", "iss_tag", int'(iss_tag), ex_e.tag);
            end
            // R7
            chk(in_ready == ex_ready, "R7", "in_ready", int'(in_ready), int'(ex_ready));
            // R3 R8
            chk(ret_valid == ex_ret, "R3", "ret_valid", int'(ret_valid), int'(ex_ret));
            if (ex_ret && ret_valid)
                chk(int'(ret_idx) == ex_ret_idx, "R3", "ret_idx", int'(ret_idx), ex_ret_idx);
            // R9
            chk(done == ex_done, "R9", "done", int'(done), int'(ex_done));
            // R2: spacing seen purely at the issue port
            if (iss_valid) begin
                chk(cyc - obs_last[iss_idx] >= LAT, "R2", "issue gap",
                    cyc - obs_last[iss_idx], LAT);
                obs_last[iss_idx] = cyc;
                issued++;
                chk(!tag_seen.exists(int'(iss_tag)), "R10", "tag issued twice",
                    int'(iss_tag), 0);
                tag_seen[int'(iss_tag)] = 1'b1;
            end
            // R11: search variant matches bitmap variant
            chk({c_ready, c_iss_valid, c_iss_idx, c_iss_tag, c_ret_valid, c_ret_idx, c_done}
                == {in_ready, iss_valid, iss_idx, iss_tag, ret_valid, ret_idx, done},
                "R11", "variant outputs", int'(c_iss_tag), int'(iss_tag));

            // advance model to the next cycle
            take = in_valid && ex_ready;
            if (take) accepted++;
            if (rgo) void'(fq.pop_front());
            if (take && (rgo || ihit)) begin
                ent_t n;
                n.idx = int'(in_idx); n.tag = int'(in_tag);
                fq.push_back(n);
            end
            if (ex_iss) begin
                fl_t f;
                f.t = cyc; f.idx = ex_e.idx;
                last_t[ex_e.idx] = cyc;
                infl.push_back(f);
            end
            if (take && in_last) ended = 1'b1;
            cyc++;
        end
    end

    task automatic send(input int b, input bit last);
        bit r;
        in_valid = 1'b1;
        in_idx   = IDX_W'(b);
        in_tag   = TAG_W'(next_tag);
        in_last  = last;
        next_tag++;
        forever begin
            @(negedge clk);
            r = in_ready;
            @(posedge clk);
            #1;
            if (r) break;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog R9: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!iss_valid, "R1", "iss_valid in reset", int'(iss_valid), 0);
        chk(!ret_valid, "R1", "ret_valid in reset", int'(ret_valid), 0);
        chk(!done, "R1", "done in reset", int'(done), 0);
        chk(in_ready, "R1", "in_ready in reset", int'(in_ready), 1);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R5: distinct buckets back to back
        for (int i = 0; i < 16; i++) send(i % NB, 1'b0);
        idle(LAT + 2);

        // R6 R7: one bucket repeated fills the retry queue
        for (int i = 0; i < 9; i++) send(1, 1'b0);
        idle(LAT * 6);

        // R8: reissue exactly LAT cycles after the previous issue
        send(2, 1'b0);
        idle(LAT - 1);
        send(2, 1'b0);
        idle(LAT - 1);
        send(2, 1'b0);
        idle(LAT + 2);

        // R4: retry entries mixed with fresh inputs on other buckets
        for (int i = 0; i < 40; i++) send((i % 3 == 0) ? 4 : (i % 5), 1'b0);
        idle(LAT * 4);

        // mixed random traffic, then end of stream
        for (int i = 0; i < 300; i++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            send((lcg >> 8) % NB, (i == 299));
            if (((lcg >> 4) & 7) == 0) idle(1);
        end

        for (int w = 0; w < 2000 && !done; w++) begin
            @(posedge clk);
            #1;
        end
        @(negedge clk);
        // R9 R10: drained completion
        chk(done, "R9", "done after drain", int'(done), 1);
        chk(issued == accepted, "R10", "issued count", issued, accepted);
        idle(3);
        @(negedge clk);
        chk(done && !iss_valid, "R9", "done held", int'(done), 1);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule